// File: doc/BRIEF.md
# Cell-Based Frame Write Controller

This block takes frames from one ingress port, one 32-bit word per accepted cycle, and stores them in a shared dual-port memory. The memory is cut into fixed cells of 64 words (256 bytes). Every frame takes fresh cells from an internal pool of free cell numbers. The cells of one frame can sit anywhere in the memory and do not need to be adjacent. The write address of a word is its cell number placed above a 6-bit word offset, so every cell begins on a 64-word boundary.

The controller does not pass frame data to the egress side. It passes cell numbers. When a cell fills up, or when a frame ends, the controller presents one queue entry to every destination port chosen at start of frame. An entry holds the cell number, a flag that marks the last cell of the frame, and the number of bytes used in that cell. Cells go back to the pool through a return input. When the pool is empty and a new cell is needed, ingress is held off. A second read port on the memory lets the egress side, or a bench, fetch stored words.

Top module: `cell_frame_writer`

## Requirements
- R1: After reset, `in_ready` is 1 and `q_push` is all zero. No queue entry appears until a word has been accepted.
- R2: An accepted word is written at address `cell*64 + offset`. The offset is 0 for the start-of-frame word and goes up by one for each later accepted word of the frame.
- R3: After reset the pool hands out cells 0, 1, 2, … 63 in ascending order. After that it hands out returned cells in the order they came back.
- R4: A frame of N words uses ceil(N/64) cells. A new cell is taken at start of frame and again after every 64th word.
- R5: The cycle after the 64th word of a cell is accepted, and that word does not end the frame, `q_push` shows one entry with `q_last`=0 and `q_len`=256.
- R6: The cycle after an end-of-frame word is accepted, `q_push` shows one entry with `q_last`=1 and `q_len` = 4*offset + bytes in the final word. `in_mod` gives the bytes in the final word, where 0 means 4 and 1 to 3 mean that many bytes. The length always lies in 1…256.
- R7: For each entry of a frame, `q_push` is set on exactly the bits of `in_dest` sampled with the start-of-frame word.
- R8: When the pool is empty and a cell is needed (a start-of-frame word, or the first word after a cell has filled), `in_ready` is 0. No write and no entry take place until a cell becomes free.
- R9: A cell returned through `ret_valid`/`ret_cell` is counted even in a cycle in which the pool also hands a cell out.
- R10: A word presented with `in_wren`=1 but with no frame open and `in_sop`=0 is dropped. It writes nothing, takes no cell and produces no entry.
- R11: `rd_data` returns the memory word at `rd_addr` one clock after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sop | input | 1 | Word starts a frame |
| in_eop | input | 1 | Word ends a frame |
| in_wren | input | 1 | Word valid |
| in_mod | input | 2 | Bytes in the final word (0 = all 4) |
| in_dest | input | NUM_PORTS | Destination mask, sampled with the start-of-frame word |
| in_data | input | DATA_W | Word data |
| in_ready | output | 1 | Word accepted at this edge when valid |
| ret_valid | input | 1 | Cell return strobe |
| ret_cell | input | 6 | Returned cell number |
| rd_addr | input | 12 | Read address of the memory read port |
| rd_data | output | DATA_W | Registered read data |
| q_push | output | NUM_PORTS | Per-port queue entry strobe |
| q_cell | output | 6 | Cell number of the entry |
| q_last | output | 1 | Entry is the frame's last cell |
| q_len | output | 9 | Bytes used in the cell (1 to 256) |

## Verification
A cell can be taken from the pool and a cell can be returned to it in the same clock, and the pool count has to stay correct when that happens. The bench first drains the pool with one large frame. It then holds a start-of-frame word that is stalled, returns one cell, and returns a second cell on the exact edge at which the stalled word is accepted. The check passes when the frame receives the two returned cells in return order and ends with a correct last-cell length, and when `in_ready` falls again at the next start of frame, showing that the pool is empty once more.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  // Bytes carried by a final word: a modulo of zero means a full word.
  function automatic int tail_bytes(input int mod_val, input int bytes_per_word);
    return (mod_val == 0) ? bytes_per_word : mod_val;
  endfunction
endpackage

// File: rtl/cfw_cell_pool.sv
module cfw_cell_pool #(
  parameter int NUM_CELLS = 64,
  localparam int CELL_W = $clog2(NUM_CELLS),
  localparam int CNT_W  = $clog2(NUM_CELLS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              ret_valid,
  input  logic [CELL_W-1:0] ret_cell,
  output logic              avail,
  output logic [CELL_W-1:0] head_cell
);
  // Never-used cells come from a counter; recycled cells from a ring.
  logic [CNT_W-1:0]  fresh, held;
  logic [CELL_W-1:0] rd_ptr, wr_ptr;
  logic [CELL_W-1:0] ring [NUM_CELLS];
  logic fresh_left, pop, push;

  always_comb begin
    fresh_left = (fresh != CNT_W'(NUM_CELLS));
    avail      = fresh_left | (held != '0);
    head_cell  = fresh_left ? fresh[CELL_W-1:0] : ring[rd_ptr];
    pop        = take & ~fresh_left & (held != '0);
    push       = ret_valid & (held != CNT_W'(NUM_CELLS));
  end

  always_ff @(posedge clk) begin
    if (push) ring[wr_ptr] <= ret_cell;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh  <= '0;
      held   <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      if (take && fresh_left) fresh <= fresh + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == CELL_W'(NUM_CELLS - 1)) ? '0 : rd_ptr + 1'b1;
      if (push) wr_ptr <= (wr_ptr == CELL_W'(NUM_CELLS - 1)) ? '0 : wr_ptr + 1'b1;
      case ({push, pop})
        2'b10:   held <= held + 1'b1;
        2'b01:   held <= held - 1'b1;
        default: held <= held;
      endcase
    end
  end
endmodule

// File: rtl/cfw_shared_mem.sv
module cfw_shared_mem #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cfw_wr_ctl.sv
module cfw_wr_ctl #(
  parameter int DATA_W     = 32,
  parameter int CELL_WORDS = 64,
  parameter int CELL_W     = 6,
  parameter int NUM_PORTS  = 4,
  localparam int BYTES  = DATA_W / 8,
  localparam int MOD_W  = $clog2(BYTES),
  localparam int OFS_W  = $clog2(CELL_WORDS),
  localparam int ADDR_W = CELL_W + OFS_W,
  localparam int LEN_W  = $clog2(CELL_WORDS * BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_sop,
  input  logic                 in_eop,
  input  logic                 in_wren,
  input  logic [MOD_W-1:0]     in_mod,
  input  logic [NUM_PORTS-1:0] in_dest,
  output logic                 in_ready,
  input  logic                 pool_avail,
  input  logic [CELL_W-1:0]    pool_cell,
  output logic                 pool_take,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [NUM_PORTS-1:0] q_push,
  output logic [CELL_W-1:0]    q_cell,
  output logic                 q_last,
  output logic [LEN_W-1:0]     q_len
);
  logic                 in_frame;
  logic [OFS_W-1:0]     ofs;
  logic [CELL_W-1:0]    cur_cell;
  logic [NUM_PORTS-1:0] dest_r;

  logic                 active, need_cell, accept, cell_full, end_cell;
  logic [CELL_W-1:0]    wcell;
  logic [OFS_W-1:0]     wofs;
  logic [NUM_PORTS-1:0] dest_now;
  logic [LEN_W-1:0]     len_now;

  always_comb begin
    active    = in_sop | in_frame;
    need_cell = in_sop | (ofs == '0);
    in_ready  = pool_avail | (in_frame & ~in_sop & (ofs != '0));
    accept    = in_wren & in_ready & active;
    pool_take = accept & need_cell;
    wcell     = need_cell ? pool_cell : cur_cell;
    wofs      = in_sop ? '0 : ofs;
    cell_full = (wofs == OFS_W'(CELL_WORDS - 1));
    end_cell  = accept & (in_eop | cell_full);
    dest_now  = in_sop ? in_dest : dest_r;
    len_now   = in_eop
              ? LEN_W'(LEN_W'(wofs) * LEN_W'(BYTES)
                       + LEN_W'(cfw_pkg::tail_bytes(int'(in_mod), BYTES)))
              : LEN_W'(CELL_WORDS * BYTES);
    mem_we    = accept;
    mem_addr  = {wcell, wofs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      ofs      <= '0;
      cur_cell <= '0;
      dest_r   <= '0;
    end else if (accept) begin
      in_frame <= ~in_eop;
      ofs      <= (cell_full | in_eop) ? '0 : wofs + 1'b1;
      cur_cell <= wcell;
      dest_r   <= dest_now;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_push
    always_ff @(posedge clk) begin
      if (rst) q_push[p] <= 1'b0;
      else     q_push[p] <= end_cell & dest_now[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cell <= '0;
      q_last <= 1'b0;
      q_len  <= '0;
    end else if (end_cell) begin
      q_cell <= wcell;
      q_last <= in_eop;
      q_len  <= len_now;
    end
  end
endmodule

// File: rtl/cell_frame_writer.sv
module cell_frame_writer #(
  parameter int DATA_W     = 32,
  parameter int CELL_WORDS = 64,
  parameter int NUM_CELLS  = 64,
  parameter int NUM_PORTS  = 4,
  localparam int BYTES  = DATA_W / 8,
  localparam int MOD_W  = $clog2(BYTES),
  localparam int OFS_W  = $clog2(CELL_WORDS),
  localparam int CELL_W = $clog2(NUM_CELLS),
  localparam int ADDR_W = CELL_W + OFS_W,
  localparam int LEN_W  = $clog2(CELL_WORDS * BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_sop,
  input  logic                 in_eop,
  input  logic                 in_wren,
  input  logic [MOD_W-1:0]     in_mod,
  input  logic [NUM_PORTS-1:0] in_dest,
  input  logic [DATA_W-1:0]    in_data,
  output logic                 in_ready,
  input  logic                 ret_valid,
  input  logic [CELL_W-1:0]    ret_cell,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_PORTS-1:0] q_push,
  output logic [CELL_W-1:0]    q_cell,
  output logic                 q_last,
  output logic [LEN_W-1:0]     q_len
);
  logic              pool_avail, pool_take, mem_we;
  logic [CELL_W-1:0] pool_cell;
  logic [ADDR_W-1:0] mem_addr;

  cfw_cell_pool #(.NUM_CELLS(NUM_CELLS)) u_pool (
    .clk(clk), .rst(rst), .take(pool_take),
    .ret_valid(ret_valid), .ret_cell(ret_cell),
    .avail(pool_avail), .head_cell(pool_cell)
  );

  cfw_wr_ctl #(
    .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS),
    .CELL_W(CELL_W), .NUM_PORTS(NUM_PORTS)
  ) u_ctl (
    .clk(clk), .rst(rst),
    .in_sop(in_sop), .in_eop(in_eop), .in_wren(in_wren),
    .in_mod(in_mod), .in_dest(in_dest), .in_ready(in_ready),
    .pool_avail(pool_avail), .pool_cell(pool_cell), .pool_take(pool_take),
    .mem_we(mem_we), .mem_addr(mem_addr),
    .q_push(q_push), .q_cell(q_cell), .q_last(q_last), .q_len(q_len)
  );

  cfw_shared_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(in_data),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/cfw_checker.sv
module cfw_checker #(
  parameter int NUM_PORTS  = 4,
  parameter int LEN_W      = 9,
  parameter int CELL_BYTES = 256
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_ready,
  input logic                 pool_avail,
  input logic                 pool_take,
  input logic                 mem_we,
  input logic [NUM_PORTS-1:0] q_push,
  input logic                 q_last,
  input logic [LEN_W-1:0]     q_len
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q_push == '0)) else $error("reset idle"); // R1

  AST_STALL_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> !pool_avail) else $error("stall with free cells"); // R8

  AST_TAKE_GRANTED: assert property (@(posedge clk) disable iff (rst)
    pool_take |-> pool_avail) else $error("cell taken from empty pool"); // R8

  AST_PUSH_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (q_push != '0) |-> $past(mem_we)) else $error("entry without write"); // R6

  AST_FULL_CELL_LEN: assert property (@(posedge clk) disable iff (rst)
    ((q_push != '0) && !q_last) |-> (q_len == LEN_W'(CELL_BYTES)))
    else $error("full cell length"); // R5

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (q_push != '0) |-> ((q_len != '0) && (q_len <= LEN_W'(CELL_BYTES))))
    else $error("length out of range"); // R6
endmodule

bind cell_frame_writer cfw_checker #(
  .NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W), .CELL_BYTES(CELL_WORDS * BYTES)
) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready),
  .pool_avail(pool_avail), .pool_take(pool_take), .mem_we(mem_we),
  .q_push(q_push), .q_last(q_last), .q_len(q_len)
);

// File: tb/tb_cell_frame_writer.sv
`timescale 1ns/1ps
module tb_cell_frame_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_sop = 0, in_eop = 0, in_wren = 0;
  logic [1:0]  in_mod = 0;
  logic [3:0]  in_dest = 0;
  logic [31:0] in_data = 0;
  logic        in_ready;
  logic        ret_valid = 0;
  logic [5:0]  ret_cell = 0;
  logic [11:0] rd_addr = 0;
  logic [31:0] rd_data;
  logic [3:0]  q_push;
  logic [5:0]  q_cell;
  logic        q_last;
  logic [8:0]  q_len;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cell_frame_writer dut (
    .clk(clk), .rst(rst), .in_sop(in_sop), .in_eop(in_eop), .in_wren(in_wren),
    .in_mod(in_mod), .in_dest(in_dest), .in_data(in_data), .in_ready(in_ready),
    .ret_valid(ret_valid), .ret_cell(ret_cell), .rd_addr(rd_addr), .rd_data(rd_data),
    .q_push(q_push), .q_cell(q_cell), .q_last(q_last), .q_len(q_len)
  );

  // Entry log, filled away from the active edge.
  int lg_n = 0;
  int lg_cell [256];
  int lg_last [256];
  int lg_len  [256];
  int lg_mask [256];
  always @(negedge clk) begin
    if (!rst && q_push != 0 && lg_n < 256) begin
      lg_cell[lg_n] = int'(q_cell);
      lg_last[lg_n] = int'(q_last);
      lg_len[lg_n]  = int'(q_len);
      lg_mask[lg_n] = int'(q_push);
      lg_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_frame(input int n, input int m, input logic [3:0] d, input int id);
    for (int w = 0; w < n; w++) begin
      @(negedge clk);
      in_wren = 1; in_sop = (w == 0); in_eop = (w == n - 1);
      in_mod  = (w == n - 1) ? m[1:0] : 2'd0;
      in_dest = d; in_data = {id[7:0], w[23:0]};
      #1;
      while (!in_ready) begin
        @(negedge clk); #1;
      end
    end
    @(negedge clk);
    in_wren = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic read_word(input int addr, output logic [31:0] val);
    @(negedge clk); rd_addr = addr[11:0];
    @(negedge clk); val = rd_data;
  endtask

  function automatic int last_len(input int n, input int m);
    return ((n - 1) % 64) * 4 + ((m == 0) ? 4 : m);
  endfunction

  // Checks entries of a frame that got consecutive cells from first_cell.
  task automatic check_frame(input int base, input int n, input int m,
                             input logic [3:0] d, input int id, input int first_cell);
    int ncell = (n + 63) / 64;
    logic [31:0] v;
    chk(lg_n - base == ncell, "R4", "entry count", lg_n - base, ncell);
    for (int k = 0; k < ncell && base + k < lg_n; k++) begin
      int el = (k == ncell - 1) ? 1 : 0;
      int ln = el ? last_len(n, m) : 256;
      chk(lg_cell[base+k] == first_cell + k, "R3", "cell number", lg_cell[base+k], first_cell + k);
      chk(lg_last[base+k] == el, el ? "R6" : "R5", "last flag", lg_last[base+k], el);
      chk(lg_len[base+k] == ln, el ? "R6" : "R5", "cell length", lg_len[base+k], ln);
      chk(lg_mask[base+k] == int'(d), "R7", "destination mask", lg_mask[base+k], d);
    end
    read_word(first_cell * 64, v);
    chk(v == {id[7:0], 24'd0}, "R2", "first word", v, {id[7:0], 24'd0});
    read_word((first_cell + ncell - 1) * 64 + (n - 1) % 64, v);
    chk(v == {id[7:0], 24'(n - 1)}, "R11", "last word", v, {id[7:0], 24'(n - 1)});
  endtask

  // words[15:0], mod[1:0], dest[3:0]
  localparam logic [21:0] VEC [7] = '{
    {16'd1,   2'd1, 4'b0001},
    {16'd1,   2'd0, 4'b0010},
    {16'd64,  2'd0, 4'b1111},
    {16'd65,  2'd3, 4'b0101},
    {16'd63,  2'd2, 4'b1000},
    {16'd130, 2'd1, 4'b0011},
    {16'd128, 2'd0, 4'b0100}
  };

  initial begin
    int exp_next = 0;
    int base;
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    chk(q_push == 4'd0, "R1", "no entry after reset", q_push, 0);

    // Vector table of frames.
    for (int i = 0; i < 7; i++) begin
      int n = int'(VEC[i][21:6]);
      int m = int'(VEC[i][5:4]);
      base = lg_n;
      send_frame(n, m, VEC[i][3:0], 16 + i);
      @(negedge clk);
      check_frame(base, n, m, VEC[i][3:0], 16 + i, exp_next);
      exp_next += (n + 63) / 64;
    end

    // R10: word outside a frame without start flag is dropped.
    base = lg_n;
    @(negedge clk);
    in_wren = 1; in_sop = 0; in_eop = 1; in_dest = 4'b1111; in_data = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    in_wren = 0; in_eop = 0;
    @(negedge clk);
    chk(lg_n == base, "R10", "entries after stray word", lg_n - base, 0);
    send_frame(1, 2, 4'b0010, 40);
    @(negedge clk);
    check_frame(base, 1, 2, 4'b0010, 40, exp_next);  // R10: cell not consumed
    exp_next += 1;

    // Drain the pool with one frame filling every remaining cell.
    base = lg_n;
    send_frame((64 - exp_next) * 64, 0, 4'b1001, 41);
    @(negedge clk);
    check_frame(base, (64 - exp_next) * 64, 0, 4'b1001, 41, exp_next);

    // R8: empty pool stalls a start-of-frame word.
    base = lg_n;
    @(negedge clk);
    in_wren = 1; in_sop = 1; in_eop = 0; in_dest = 4'b0110; in_data = 32'h2A00_0000;
    #1;
    chk(in_ready == 1'b0, "R8", "ready with empty pool", in_ready, 0);
    repeat (3) @(negedge clk);
    chk(lg_n == base, "R8", "entries while stalled", lg_n - base, 0);
    in_wren = 0; in_sop = 0;

    // R9: return cell 5, then return cell 7 on the edge that takes cell 5.
    base = lg_n;
    fork
      send_frame(65, 1, 4'b0110, 42);
      begin
        @(negedge clk); ret_valid = 1; ret_cell = 6'd5;
        @(negedge clk); ret_cell = 6'd7;
        @(negedge clk); ret_valid = 0;
      end
    join
    @(negedge clk);
    chk(lg_n - base == 2, "R9", "entries of refilled frame", lg_n - base, 2);
    chk(lg_cell[base] == 5, "R9", "first returned cell", lg_cell[base], 5);
    chk(lg_cell[base+1] == 7, "R9", "second returned cell", lg_cell[base+1], 7);
    chk(lg_len[base+1] == last_len(65, 1), "R6", "last length", lg_len[base+1], last_len(65, 1));
    read_word(5 * 64, v);
    chk(v == 32'h2A00_0000, "R2", "stalled word stored once", v, 32'h2A00_0000);
    read_word(7 * 64, v);
    chk(v == {8'd42, 24'd64}, "R4", "word after wrap", v, {8'd42, 24'd64});
    @(negedge clk);
    in_wren = 1; in_sop = 1; #1;
    chk(in_ready == 1'b0, "R9", "pool empty again", in_ready, 0);
    @(negedge clk);
    in_wren = 0; in_sop = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule